// File: doc/BRIEF.md
# Asynchronous Host Bus Slave Interface

This block is the slave side of an asynchronous host bus for a peripheral's small register bank. A host reaches the bank with an address, an address-enable qualifier, four active-low byte enables, and separate active-low read and write strobes. The block can be attached to the host in three ways. In the first, the address stays stable for the whole transfer and passes through unchanged. In the second, the address is captured on the rising edge of an address strobe. In the third, an external chip-select bypasses the local decoder and reaches only the 32-bit data register.

Write data lands in the addressed register on the rising edge of the write strobe. Read data is driven for as long as the read strobe stays low, so the host can sample it on the rising edge. An internal clock runs a wait-state generator. It pulls the ready output low for a programmable number of cycles during each targeted access. The strobes pass through two-flop synchronizers before this generator sees them.

The bank holds four 32-bit words. Word index = address bits [3:2]. Index 0 is the data register.

Top module: `hbiu_async`

## Requirements
- R1: While `as_n_i` is high, decode and register selection use the address bits [15:1], qualifier and byte enables captured at the most recent rising edge of `as_n_i`. Later changes on those inputs have no effect.
- R2: While `as_n_i` is low, the live address, qualifier and byte enables are used directly, and `dev_sel_n_o` follows them without any clock.
- R3: `dev_sel_n_o` is low exactly when the effective qualifier is 1 and effective address bits [15:4] equal `BASE_ADDR` (default 12'h030). It depends on nothing else.
- R4: On a locally decoded access, the rising edge of `wr_n_i` writes `wdata_i` into word address[3:2]. Byte lane k (bits 8k+7:8k) is written only when `ben_n_i[k]` is 0. Lanes whose enable is 1 keep their value.
- R5: While `rd_n_i` is low on a targeted access, `rdata_oe_o` is 1 and `rdata_o` carries the addressed word. At all other times `rdata_oe_o` is 0 and `rdata_o` is 0.
- R6: While `cs_n_i` is low, the access targets word 0 whatever the address and qualifier are. All four byte enables are ignored, so every lane is written.
- R7: With `cs_n_i` low, words 1 to 3 are unreachable. A write carrying their address modifies word 0 only.
- R8: An access that is neither decoded nor chip-selected changes no word, keeps `rdata_oe_o` at 0 and inserts no wait state.
- R9: For a targeted read or write held long enough, `ready_o` is low for exactly `wait_cfg_i` clock cycles (0 to 7) during the strobe, then high until the next access.
- R10: After reset, all words read 0, `ready_o` is 1 and `rdata_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock for wait-state timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_cfg_i | input | 3 | Wait cycles inserted per targeted access |
| addr_i | input | 15 | Host address bits [15:1] |
| aen_i | input | 1 | Address qualifier, 1 = address valid for local decode |
| ben_n_i | input | 4 | Active-low byte lane enables |
| as_n_i | input | 1 | Address strobe; rising edge captures, low = pass through |
| cs_n_i | input | 1 | Active-low central chip-select, data register only |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe, data captured on rising edge |
| wdata_i | input | 32 | Write data |
| dev_sel_n_o | output | 1 | Active-low local decode result |
| rdata_o | output | 32 | Read data |
| rdata_oe_o | output | 1 | Read data drive enable, 0 = bus released |
| ready_o | output | 1 | Low while wait states are inserted |

## Verification
The byte-lane path gets a full sweep: all sixteen enable patterns on every word, with the read-back word predicted by arithmetic. This separates lane-to-bit mapping faults from faults in word selection. Decode is swept over 64 upper-address values with the qualifier on and off, and again with the address held by the strobe while the live bus carries garbage. These sweeps show apart pass-through, latched and qualifier-ignored behaviour. Chip-select writes carry all enables inactive and another word's address, which shows that lanes and word index are both forced. Wait counts 0 to 7 are measured on reads and writes, and on missed accesses the expected count is 0.

// File: rtl/hbiu_pkg.sv
package hbiu_pkg;

    localparam int ADDR_HI = 15;
    localparam int ADDR_LO = 1;
    localparam int LANES   = 4;
    localparam int WAIT_W  = 3;

    typedef struct packed {
        logic [ADDR_HI:ADDR_LO] addr;
        logic                   aen;
        logic [LANES-1:0]       ben_n;
    } hbiu_addr_t;

    typedef struct packed {
        logic [1:0]        rd_sync;
        logic [1:0]        wr_sync;
        logic [WAIT_W-1:0] cnt;
        logic              busy;
    } hbiu_wait_t;

endpackage

// File: rtl/hbiu_addr_stage.sv
module hbiu_addr_stage
    import hbiu_pkg::*;
#(
    parameter logic [11:0] BASE_ADDR = 12'h030,
    parameter int          NUM_REGS  = 4,
    parameter int          DATA_IDX  = 0,
    localparam int         IDX_W     = $clog2(NUM_REGS)
) (
    input  logic                   rst_n,
    input  logic                   as_n_i,
    input  logic [ADDR_HI:ADDR_LO] addr_i,
    input  logic                   aen_i,
    input  logic [LANES-1:0]       ben_n_i,
    input  logic                   cs_n_i,
    output logic                   dev_sel_o,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic [LANES-1:0]       lane_en_o
);

    hbiu_addr_t lat_d, lat_q, eff;
    logic       cs_hit;

    // next value of the address holding register
    always_comb begin
        lat_d.addr  = addr_i;
        lat_d.aen   = aen_i;
        lat_d.ben_n = ben_n_i;
    end

    always_ff @(posedge as_n_i or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    // strobe low: pass through, strobe high: hold captured copy
    always_comb begin
        eff       = as_n_i ? lat_q : lat_d;
        cs_hit    = !cs_n_i;
        dev_sel_o = eff.aen && (eff.addr[ADDR_HI:4] == BASE_ADDR);
        hit_o     = cs_hit || dev_sel_o;
        idx_o     = cs_hit ? IDX_W'(DATA_IDX) : eff.addr[2+IDX_W-1:2];
        lane_en_o = cs_hit ? {LANES{1'b1}} : ~eff.ben_n;
    end

endmodule

// File: rtl/hbiu_regbank.sv
module hbiu_regbank
    import hbiu_pkg::*;
#(
    parameter int  NUM_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int DATA_W   = LANES * 8
) (
    input  logic              rst_n,
    input  logic              wr_n_i,
    input  logic              rd_n_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            for (int k = 0; k < LANES; k++) begin
                if (hit_i && (idx_i == IDX_W'(r)) && lane_en_i[k]) begin
                    bank_d[r][k*8 +: 8] = wdata_i[k*8 +: 8];
                end
            end
        end
    end

    // write data lands on the rising edge of the write strobe
    always_ff @(posedge wr_n_i or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rdata_oe_o = hit_i && !rd_n_i;
        rdata_o    = rdata_oe_o ? bank_q[idx_i] : '0;
    end

endmodule

// File: rtl/hbiu_wait_ctrl.sv
module hbiu_wait_ctrl
    import hbiu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              hit_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    output logic              rd_seen_n_o,
    output logic              wr_seen_n_o,
    output logic              ready_o
);

    hbiu_wait_t st_d, st_q;
    logic       active;

    always_comb begin
        st_d         = st_q;
        st_d.rd_sync = {st_q.rd_sync[0], rd_n_i};
        st_d.wr_sync = {st_q.wr_sync[0], wr_n_i};
        active       = !st_q.rd_sync[1] || !st_q.wr_sync[1];
        if (!active) begin
            st_d.cnt  = '0;
            st_d.busy = 1'b0;
        end else begin
            st_d.busy = hit_i && (st_q.cnt < wait_cfg_i);
            if (st_q.cnt < wait_cfg_i) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd_sync <= 2'b11;
            st_q.wr_sync <= 2'b11;
            st_q.cnt     <= '0;
            st_q.busy    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_seen_n_o = st_q.rd_sync[1];
    assign wr_seen_n_o = st_q.wr_sync[1];
    assign ready_o     = !st_q.busy;

endmodule

// File: rtl/hbiu_async.sv
module hbiu_async
    import hbiu_pkg::*;
#(
    parameter logic [11:0] BASE_ADDR = 12'h030,
    parameter int          NUM_REGS  = 4,
    parameter int          DATA_IDX  = 0,
    localparam int         IDX_W     = $clog2(NUM_REGS),
    localparam int         DATA_W    = LANES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WAIT_W-1:0]      wait_cfg_i,
    input  logic [ADDR_HI:ADDR_LO] addr_i,
    input  logic                   aen_i,
    input  logic [LANES-1:0]       ben_n_i,
    input  logic                   as_n_i,
    input  logic                   cs_n_i,
    input  logic                   rd_n_i,
    input  logic                   wr_n_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic                   dev_sel_n_o,
    output logic [DATA_W-1:0]      rdata_o,
    output logic                   rdata_oe_o,
    output logic                   ready_o
);

    logic             dev_sel, hit;
    logic [IDX_W-1:0] idx;
    logic [LANES-1:0] lane_en;
    logic             rd_seen_n, wr_seen_n;

    hbiu_addr_stage #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS),
        .DATA_IDX  (DATA_IDX)
    ) u_addr (
        .rst_n     (rst_n),
        .as_n_i    (as_n_i),
        .addr_i    (addr_i),
        .aen_i     (aen_i),
        .ben_n_i   (ben_n_i),
        .cs_n_i    (cs_n_i),
        .dev_sel_o (dev_sel),
        .hit_o     (hit),
        .idx_o     (idx),
        .lane_en_o (lane_en)
    );

    hbiu_regbank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .rst_n      (rst_n),
        .wr_n_i     (wr_n_i),
        .rd_n_i     (rd_n_i),
        .hit_i      (hit),
        .idx_i      (idx),
        .lane_en_i  (lane_en),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .rdata_oe_o (rdata_oe_o)
    );

    hbiu_wait_ctrl u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_n_i      (rd_n_i),
        .wr_n_i      (wr_n_i),
        .hit_i       (hit),
        .wait_cfg_i  (wait_cfg_i),
        .rd_seen_n_o (rd_seen_n),
        .wr_seen_n_o (wr_seen_n),
        .ready_o     (ready_o)
    );

    assign dev_sel_n_o = !dev_sel;

endmodule

// File: rtl/hbiu_async_chk.sv
module hbiu_async_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       as_n_i,
    input logic       aen_i,
    input logic       cs_n_i,
    input logic       rd_n_i,
    input logic [2:0] wait_cfg_i,
    input logic       dev_sel_n_o,
    input logic       rdata_oe_o,
    input logic       ready_o,
    input logic       rd_seen_n,
    input logic       wr_seen_n
);

    // R9: no synchronized strobe means ready is released on the next cycle
    a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_seen_n && wr_seen_n) |=> ready_o);

    // R9: a zero wait setting never stretches a cycle
    a_r9_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o) |-> ($past(wait_cfg_i) != 3'd0));

    // R5: data is driven only inside a read strobe
    a_r5_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe_o |-> !rd_n_i);

    // R8: driving requires a decode hit or chip-select
    a_r8_oe_targeted: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe_o |-> (!cs_n_i || !dev_sel_n_o));

    // R2, R3: with the address passing through, a decode needs the live qualifier
    a_r3_sel_needs_aen: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n_i && !dev_sel_n_o) |-> aen_i);

endmodule

bind hbiu_async hbiu_async_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_n_i      (as_n_i),
    .aen_i       (aen_i),
    .cs_n_i      (cs_n_i),
    .rd_n_i      (rd_n_i),
    .wait_cfg_i  (wait_cfg_i),
    .dev_sel_n_o (dev_sel_n_o),
    .rdata_oe_o  (rdata_oe_o),
    .ready_o     (ready_o),
    .rd_seen_n   (rd_seen_n),
    .wr_seen_n   (wr_seen_n)
);

// File: tb/hbiu_async_tb.sv
module hbiu_async_tb;

    localparam logic [11:0] BASE = 12'h030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  wait_cfg = 3'd0;
    logic [15:1] addr = '0;
    logic        aen = 1'b0;
    logic [3:0]  ben_n = 4'hF;
    logic        as_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [31:0] wdata = '0;
    logic        dev_sel_n;
    logic [31:0] rdata;
    logic        rdata_oe;
    logic        ready;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [4];

    always #2 clk = ~clk;

    hbiu_async u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_cfg_i  (wait_cfg),
        .addr_i      (addr),
        .aen_i       (aen),
        .ben_n_i     (ben_n),
        .as_n_i      (as_n),
        .cs_n_i      (cs_n),
        .rd_n_i      (rd_n),
        .wr_n_i      (wr_n),
        .wdata_i     (wdata),
        .dev_sel_n_o (dev_sel_n),
        .rdata_o     (rdata),
        .rdata_oe_o  (rdata_oe),
        .ready_o     (ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:1] waddr(input logic [11:0] hi, input int idx);
        return {hi, idx[1:0], 1'b0};
    endfunction

    // strobe held 14 cycles; count cycles with ready low
    task automatic do_write(input logic [31:0] d, output int waits);
        waits = 0;
        @(negedge clk);
        wdata = d;
        #1 wr_n = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (!ready) waits++;
        end
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(output logic [31:0] d, output logic oe, output int waits);
        waits = 0;
        @(negedge clk);
        #1 rd_n = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (!ready) waits++;
        end
        d  = rdata;
        oe = rdata_oe;
        rd_n = 1'b1;
        #1;
        repeat (4) @(negedge clk);
    endtask

    task automatic local_read(input int idx, output logic [31:0] d, output logic oe);
        int w;
        as_n = 1'b0; cs_n = 1'b1; aen = 1'b1; ben_n = 4'h0;
        addr = waddr(BASE, idx);
        do_read(d, oe, w);
    endtask

    task automatic check_bank(input string req);
        logic [31:0] d;
        logic oe;
        for (int r = 0; r < 4; r++) begin
            local_read(r, d, oe);
            chk(oe === 1'b1 && d === model[r], req, d, model[r]);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic oe;
        int w;
        for (int r = 0; r < 4; r++) model[r] = '0;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ready === 1'b1, "R10 ready", {31'd0, ready}, 32'd1);
        chk(rdata_oe === 1'b0, "R10 oe", {31'd0, rdata_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_bank("R10 bank zero");

        // R3 / R2: decode sweep with address passing through
        as_n = 1'b0; cs_n = 1'b1;
        for (int h = 0; h < 64; h++) begin
            for (int a = 0; a < 2; a++) begin
                addr = waddr(12'(h), h % 4);
                aen  = a[0];
                #1;
                chk(dev_sel_n === !(a == 1 && 12'(h) == BASE), "R3 R2 decode",
                    {31'd0, dev_sel_n}, {31'd0, !(a == 1 && 12'(h) == BASE)});
            end
        end

        // R4: byte lane sweep over every word and enable pattern
        wait_cfg = 3'd1;
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 16; b++) begin
                logic [31:0] val;
                val = 32'h9E37_79B9 * (r * 16 + b + 1);
                as_n = 1'b0; cs_n = 1'b1; aen = 1'b1;
                addr = waddr(BASE, r); ben_n = b[3:0];
                do_write(val, w);
                for (int k = 0; k < 4; k++)
                    if (!b[k]) model[r][k*8 +: 8] = val[k*8 +: 8];
                local_read(r, d, oe);
                chk(oe === 1'b1 && d === model[r], "R4 R5 lanes", d, model[r]);
            end
        end
        check_bank("R4 other words intact");

        // R1: address captured on the strobe rising edge, live bus then garbage
        @(negedge clk);
        addr = waddr(BASE, 1); aen = 1'b1; ben_n = 4'h0; as_n = 1'b0;
        #1 as_n = 1'b1;
        #1 addr = 15'h7FFF; aen = 1'b0; ben_n = 4'hF;
        #1;
        chk(dev_sel_n === 1'b0, "R1 held decode", {31'd0, dev_sel_n}, 32'd0);
        do_write(32'hCAFE_0101, w);
        model[1] = 32'hCAFE_0101;
        do_read(d, oe, w);
        chk(oe === 1'b1 && d === 32'hCAFE_0101, "R1 held read", d, 32'hCAFE_0101);
        // R1: a capture with qualifier off blocks a live valid address
        @(negedge clk);
        addr = waddr(BASE, 2); aen = 1'b0; as_n = 1'b0;
        #1 as_n = 1'b1;
        #1 aen = 1'b1;
        #1;
        chk(dev_sel_n === 1'b1, "R1 held miss", {31'd0, dev_sel_n}, 32'd1);
        // R2: dropping the strobe lets the live bus through
        as_n = 1'b0;
        #1;
        chk(dev_sel_n === 1'b0, "R2 pass through", {31'd0, dev_sel_n}, 32'd0);
        check_bank("R1 bank");

        // R6: chip-select ignores address, qualifier and byte enables
        as_n = 1'b0; cs_n = 1'b0; aen = 1'b0; ben_n = 4'hF; addr = 15'h0123;
        do_write(32'h1357_9BDF, w);
        model[0] = 32'h1357_9BDF;
        do_read(d, oe, w);
        chk(oe === 1'b1 && d === 32'h1357_9BDF, "R6 cs read", d, 32'h1357_9BDF);
        // R7: chip-select with word 2 address still reaches word 0
        addr = waddr(BASE, 2); aen = 1'b1; ben_n = 4'h0;
        do_write(32'h2468_ACE0, w);
        model[0] = 32'h2468_ACE0;
        cs_n = 1'b1;
        check_bank("R7 cs bypass");

        // R8: miss accesses change nothing, release the bus, no waits
        wait_cfg = 3'd5;
        as_n = 1'b0; cs_n = 1'b1; aen = 1'b0; ben_n = 4'h0; addr = waddr(BASE, 3);
        do_write(32'hFFFF_FFFF, w);
        chk(w == 0, "R8 write waits", w, 0);
        do_read(d, oe, w);
        chk(oe === 1'b0 && d === 32'd0, "R8 read released", {31'd0, oe}, 32'd0);
        chk(w == 0, "R8 read waits", w, 0);
        aen = 1'b1; addr = waddr(12'h031, 3);
        do_write(32'hFFFF_FFFF, w);
        check_bank("R8 bank unchanged");

        // R9: exact wait counts on reads and writes
        for (int c = 0; c < 8; c++) begin
            wait_cfg = 3'(c);
            as_n = 1'b0; cs_n = 1'b1; aen = 1'b1; ben_n = 4'h0; addr = waddr(BASE, 3);
            do_write(32'h0F0F_0000 + 32'(c), w);
            model[3] = 32'h0F0F_0000 + 32'(c);
            chk(w == c, "R9 write waits", w, c);
            do_read(d, oe, w);
            chk(w == c, "R9 read waits", w, c);
            chk(d === model[3], "R9 read data", d, model[3]);
            chk(ready === 1'b1, "R9 released", {31'd0, ready}, 32'd1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule